// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDR SDRAM from power-on to its operating state. Once reset is released it drives the command pins through a fixed sequence: a long stretch of NOP cycles with the clock enable high, one precharge of every bank, a burst of auto-refresh commands, and a load of the device mode register. After that it idles on NOP and raises `init_done`, so that the normal-mode controller can take over the command bus.

Each wait in the sequence is a run-time input counted in clock cycles: the power-up delay, the precharge period, the refresh cycle time and the mode-load delay. One down-counter enforces all of these waits. The mode word is built from parameters (burst length, burst type, CAS latency, write-burst mode). The block drives the mode word onto the SDRAM address pins. It also gives the host-side address at which a controller must place that word. That address is the word shifted left by the column bits plus the bus-width code plus, for standard parts only, the bank bits.

During initialization the block asks the refresh timer for its shortest interval. When initialization ends it switches the request to the operating interval, counted in units of 16 clocks.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and for the two clocks of the reset synchronizer after its release, the outputs are: CKE low, command NOP ({CS_n,RAS_n,CAS_n,WE_n}=0111), `init_done` 0, `rfsh_fast` 1, `rfsh_units` 1.
- R2: After that, CKE is high and the command is NOP for exactly max(`cfg_pwrup_cycles`,1) cycles. A PRECHARGE follows (0010) with A10=1 and every other address bit 0.
- R3: The first AUTO REFRESH (0001) comes exactly max(`cfg_trp`,2) cycles after the PRECHARGE, with NOP in between.
- R4: Consecutive AUTO REFRESH commands are spaced exactly max(`cfg_trfc`,2) cycles apart, with NOP in between. At least NUM_REF (default 2) of them are issued.
- R5: LOAD MODE (0000) is issued max(`cfg_trfc`,2) cycles after the last refresh. It is issued at the first such point where at least NUM_REF refreshes have been sent and at least MIN_REF_PHASE (default 128) cycles have passed since the PRECHARGE.
- R6: During LOAD MODE the address pins carry the mode word in bits 9:0: bits 2:0 burst length (default 011 = 8), bit 3 burst type (0 sequential), bits 6:4 CAS latency (default 3), bits 8:7 operating mode (00), bit 9 write-burst mode (0). Higher address bits and the bank pins are 0, so the default word is 0x033.
- R7: `mode_host_addr` equals the mode word shifted left by COL_BITS+BUS_CODE+BANK_BITS during LOAD MODE (0x33000 with defaults 9,1,2), and 0 otherwise. With LOW_POWER=1 the bank term is left out.
- R8: `init_done` rises exactly max(`cfg_tmrd`,2) cycles after LOAD MODE, with NOP in between. It then stays high and the command stays NOP.
- R9: Before `init_done`, `rfsh_fast`=1 and `rfsh_units`=1. From `init_done` on, `rfsh_fast`=0 and `rfsh_units` = `cfg_rfsh_clks` shifted right by 4.
- R10: Once CKE has gone high it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwrup_cycles | input | 16 | Power-up NOP duration in cycles |
| cfg_trp | input | 8 | Precharge period in cycles |
| cfg_trfc | input | 8 | Auto-refresh cycle time in cycles |
| cfg_tmrd | input | 8 | Mode-load to next command delay in cycles |
| cfg_rfsh_clks | input | 16 | Operating refresh interval in clocks |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| ba | output | BANK_BITS | Bank address |
| addr | output | ADDR_W | Row/mode address pins |
| mode_host_addr | output | HOST_AW | Host-side address carrying the shifted mode word |
| init_done | output | 1 | Initialization complete |
| rfsh_fast | output | 1 | Request shortest refresh interval |
| rfsh_units | output | 12 | Refresh interval request in 16-clock units |

## Verification
The hardest case to reach is the exit from the refresh phase. The decision depends on two conditions at once: the refresh count and the 128-cycle phase floor. Which of the two ends the loop depends on the refresh spacing. The stimulus therefore runs full initializations with short spacing, where the phase floor governs and about a dozen refreshes occur. It also runs them with long spacing, where only the minimum two refreshes occur. A third run sets every timing input to 0 or 1 to exercise the clamping of waits. The bench compares every output on every cycle against a schedule built from these rules. A second instance built as a low-power part checks the shortened host-address shift.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_PWRUP,
    ST_PREA,
    ST_TRP,
    ST_AREF,
    ST_TRFC,
    ST_LMR,
    ST_TMRD,
    ST_RUN
  } init_state_e;

  localparam int MODE_W = 10;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] op_mode;
    logic [2:0] cas_lat;
    logic       interleave;
    logic [2:0] burst_code;
  } mode_word_t;

  // counter preload so that a wait spans max(cyc,floor) cycles
  function automatic int unsigned wait_load(input int unsigned cyc,
                                            input int unsigned floor);
    return (cyc >= floor) ? (cyc - floor) : 0;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_en | (cnt_q != '0);
    cnt_d  = load_en ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TW            = 8,
  parameter int NUM_REF       = 2,
  parameter int MIN_REF_PHASE = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_pwrup_cycles,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_trfc,
  input  logic [TW-1:0]    cfg_tmrd,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic [3:0]       cmd,
  output logic             is_prea,
  output logic             is_lmr,
  output logic             done
);
  localparam int RC_W   = $clog2(NUM_REF + 1);
  localparam int PH_W   = $clog2(MIN_REF_PHASE + 1);
  localparam int PH_MAX = MIN_REF_PHASE - 1;

  init_state_e      state_q, state_d;
  logic [RC_W-1:0]  ref_q;
  logic             ref_en;
  logic [PH_W-1:0]  ph_q;
  logic             ph_en;
  logic             ref_enough;
  logic             ph_enough;

  always_comb begin
    ref_en     = (state_q == ST_AREF) && (ref_q != RC_W'(NUM_REF));
    ph_en      = ((state_q == ST_PREA) || (state_q == ST_TRP) ||
                  (state_q == ST_AREF) || (state_q == ST_TRFC)) &&
                 (ph_q != PH_W'(PH_MAX));
    ref_enough = (ref_q == RC_W'(NUM_REF));
    ph_enough  = (ph_q == PH_W'(PH_MAX));
  end

  // next-state and counter preload
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_HOLD: begin
        state_d  = ST_PWRUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(wait_load(32'(cfg_pwrup_cycles), 1));
      end
      ST_PWRUP: if (tmr_expired) state_d = ST_PREA;
      ST_PREA: begin
        state_d  = ST_TRP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(wait_load(32'(cfg_trp), 2));
      end
      ST_TRP: if (tmr_expired) state_d = ST_AREF;
      ST_AREF: begin
        state_d  = ST_TRFC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(wait_load(32'(cfg_trfc), 2));
      end
      ST_TRFC: begin
        if (tmr_expired) begin
          state_d = (ref_enough && ph_enough) ? ST_LMR : ST_AREF;
        end
      end
      ST_LMR: begin
        state_d  = ST_TMRD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(wait_load(32'(cfg_tmrd), 2));
      end
      ST_TMRD: if (tmr_expired) state_d = ST_RUN;
      ST_RUN:  state_d = ST_RUN;
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (ref_en) begin
      ref_q <= ref_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_en) begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // command decode
  always_comb begin
    unique case (state_q)
      ST_PREA: cmd = CMD_PRE;
      ST_AREF: cmd = CMD_REF;
      ST_LMR:  cmd = CMD_LMR;
      default: cmd = CMD_NOP;
    endcase
    is_prea = (state_q == ST_PREA);
    is_lmr  = (state_q == ST_LMR);
    done    = (state_q == ST_RUN);
  end
endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int BL_CODE    = 3,
  parameter int INTERLEAVE = 0,
  parameter int CAS_LAT    = 3,
  parameter int WR_SINGLE  = 0,
  parameter int COL_BITS   = 9,
  parameter int BUS_CODE   = 1,
  parameter int BANK_BITS  = 2,
  parameter int LOW_POWER  = 0,
  parameter int HOST_AW    = 32
) (
  output logic [MODE_W-1:0]  word,
  output logic [HOST_AW-1:0] host_addr
);
  mode_word_t fields;

  always_comb begin
    fields.wr_single  = 1'(WR_SINGLE);
    fields.op_mode    = 2'b00;
    fields.cas_lat    = 3'(CAS_LAT);
    fields.interleave = 1'(INTERLEAVE);
    fields.burst_code = 3'(BL_CODE);
  end

  assign word = fields;

  generate
    if (LOW_POWER != 0) begin : g_lp_shift
      localparam int SHIFT = COL_BITS + BUS_CODE;
      assign host_addr = HOST_AW'(word) << SHIFT;
    end else begin : g_std_shift
      localparam int SHIFT = COL_BITS + BUS_CODE + BANK_BITS;
      assign host_addr = HOST_AW'(word) << SHIFT;
    end
  endgenerate
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int COL_BITS      = 9,
  parameter int BUS_CODE      = 1,
  parameter int BANK_BITS     = 2,
  parameter int LOW_POWER     = 0,
  parameter int HOST_AW       = 32,
  parameter int CNT_W         = 16,
  parameter int TW            = 8,
  parameter int RF_W          = 16,
  parameter int NUM_REF       = 2,
  parameter int MIN_REF_PHASE = 128,
  parameter int BL_CODE       = 3,
  parameter int INTERLEAVE    = 0,
  parameter int CAS_LAT       = 3,
  parameter int WR_SINGLE     = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cfg_pwrup_cycles,
  input  logic [TW-1:0]        cfg_trp,
  input  logic [TW-1:0]        cfg_trfc,
  input  logic [TW-1:0]        cfg_tmrd,
  input  logic [RF_W-1:0]      cfg_rfsh_clks,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic                 cke,
  output logic [BANK_BITS-1:0] ba,
  output logic [ADDR_W-1:0]    addr,
  output logic [HOST_AW-1:0]   mode_host_addr,
  output logic                 init_done,
  output logic                 rfsh_fast,
  output logic [RF_W-5:0]      rfsh_units
);
  localparam int A10 = 10;

  logic               rst_i_n;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_expired;
  logic [3:0]         cmd;
  logic               is_prea;
  logic               is_lmr;
  logic               done;
  logic               cke_q;
  logic [MODE_W-1:0]  word;
  logic [HOST_AW-1:0] host_word;
  logic               unused_rf_low;

  sdram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_en  (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdram_init_fsm #(
    .CNT_W         (CNT_W),
    .TW            (TW),
    .NUM_REF       (NUM_REF),
    .MIN_REF_PHASE (MIN_REF_PHASE)
  ) u_fsm (
    .clk              (clk),
    .rst_n            (rst_i_n),
    .cfg_pwrup_cycles (cfg_pwrup_cycles),
    .cfg_trp          (cfg_trp),
    .cfg_trfc         (cfg_trfc),
    .cfg_tmrd         (cfg_tmrd),
    .tmr_expired      (tmr_expired),
    .tmr_load         (tmr_load),
    .tmr_val          (tmr_val),
    .cmd              (cmd),
    .is_prea          (is_prea),
    .is_lmr           (is_lmr),
    .done             (done)
  );

  sdram_mode_word #(
    .BL_CODE    (BL_CODE),
    .INTERLEAVE (INTERLEAVE),
    .CAS_LAT    (CAS_LAT),
    .WR_SINGLE  (WR_SINGLE),
    .COL_BITS   (COL_BITS),
    .BUS_CODE   (BUS_CODE),
    .BANK_BITS  (BANK_BITS),
    .LOW_POWER  (LOW_POWER),
    .HOST_AW    (HOST_AW)
  ) u_mode (
    .word      (word),
    .host_addr (host_word)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cke_q <= 1'b0;
    end else if (!cke_q) begin
      cke_q <= 1'b1;
    end
  end

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = cmd;
    cke            = cke_q;
    ba             = '0;
    addr           = '0;
    if (is_prea) addr[A10] = 1'b1;
    if (is_lmr)  addr[MODE_W-1:0] = word;
    mode_host_addr = is_lmr ? host_word : '0;
    init_done      = done;
    rfsh_fast      = !done;
    rfsh_units     = done ? cfg_rfsh_clks[RF_W-1:4] : (RF_W-4)'(1);
  end

  assign unused_rf_low = ^cfg_rfsh_clks[3:0];
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int HOST_AW    = 32,
  parameter int RF_W       = 16,
  parameter int BL_CODE    = 3,
  parameter int INTERLEAVE = 0,
  parameter int CAS_LAT    = 3,
  parameter int WR_SINGLE  = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               ras_n,
  input logic               cas_n,
  input logic               we_n,
  input logic               cke,
  input logic [ADDR_W-1:0]  addr,
  input logic [HOST_AW-1:0] mode_host_addr,
  input logic               init_done,
  input logic               rfsh_fast,
  input logic [RF_W-5:0]    rfsh_units,
  input logic [RF_W-1:0]    cfg_rfsh_clks
);
  logic [3:0]        cmd;
  logic [ADDR_W-1:0] exp_word;

  assign cmd = {cs_n, ras_n, cas_n, we_n};
  assign exp_word = ADDR_W'({1'(WR_SINGLE), 2'b00, 3'(CAS_LAT),
                             1'(INTERLEAVE), 3'(BL_CODE)});

  // R2
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (addr == (ADDR_W'(1) << 10)));

  // R3
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  // R6
  mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (addr == exp_word));

  // R7
  host_addr_only_lmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_host_addr != '0) |-> (cmd == CMD_LMR));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == CMD_NOP));

  // R9
  oper_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!rfsh_fast && (rfsh_units == cfg_rfsh_clks[RF_W-1:4])));

  // R9
  fast_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (rfsh_fast && (rfsh_units == (RF_W-4)'(1))));

  // R10
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W     (ADDR_W),
  .HOST_AW    (HOST_AW),
  .RF_W       (RF_W),
  .BL_CODE    (BL_CODE),
  .INTERLEAVE (INTERLEAVE),
  .CAS_LAT    (CAS_LAT),
  .WR_SINGLE  (WR_SINGLE)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cs_n           (cs_n),
  .ras_n          (ras_n),
  .cas_n          (cas_n),
  .we_n           (we_n),
  .cke            (cke),
  .addr           (addr),
  .mode_host_addr (mode_host_addr),
  .init_done      (init_done),
  .rfsh_fast      (rfsh_fast),
  .rfsh_units     (rfsh_units),
  .cfg_rfsh_clks  (cfg_rfsh_clks)
);

// File: tb/test_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module test_sdram_pwrup_seq;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;
  localparam int NREF      = 2;
  localparam int MIN_PHASE = 128;
  localparam int MODE_VAL  = 'h033;
  localparam int HOST_STD  = 'h033 << 12;
  localparam int HOST_LP   = 'h033 << 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_pwrup = 16'd10;
  logic [7:0]  cfg_trp = 8'd2;
  logic [7:0]  cfg_trfc = 8'd2;
  logic [7:0]  cfg_tmrd = 8'd2;
  logic [15:0] cfg_rf = 16'd448;

  logic        cs_n, ras_n, cas_n, we_n, cke, done, fast;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [31:0] host;
  logic [11:0] units;
  logic        lp_cs_n, lp_ras_n, lp_cas_n, lp_we_n, lp_cke, lp_done, lp_fast;
  logic [1:0]  lp_ba;
  logic [12:0] lp_addr;
  logic [31:0] lp_host;
  logic [11:0] lp_units;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0] exp_cmd_q[$];
  string      exp_tag_q[$];

  always #2 clk = ~clk;

  sdram_pwrup_seq i_sdram_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .cfg_pwrup_cycles(cfg_pwrup), .cfg_trp(cfg_trp),
    .cfg_trfc(cfg_trfc), .cfg_tmrd(cfg_tmrd), .cfg_rfsh_clks(cfg_rf),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
    .ba(ba), .addr(addr), .mode_host_addr(host), .init_done(done),
    .rfsh_fast(fast), .rfsh_units(units));

  sdram_pwrup_seq #(.LOW_POWER(1), .COL_BITS(8), .BUS_CODE(2)) i_sdram_pwrup_seq_lp (
    .clk(clk), .rst_n(rst_n), .cfg_pwrup_cycles(cfg_pwrup), .cfg_trp(cfg_trp),
    .cfg_trfc(cfg_trfc), .cfg_tmrd(cfg_tmrd), .cfg_rfsh_clks(cfg_rf),
    .cs_n(lp_cs_n), .ras_n(lp_ras_n), .cas_n(lp_cas_n), .we_n(lp_we_n), .cke(lp_cke),
    .ba(lp_ba), .addr(lp_addr), .mode_host_addr(lp_host), .init_done(lp_done),
    .rfsh_fast(lp_fast), .rfsh_units(lp_units));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: got %0h expected %0h", tag, what, $time, act, exp);
    end
  endtask

  function automatic int atleast(input int v, input int floor);
    return (v < floor) ? floor : v;
  endfunction

  // behavioural schedule of commands from power-up index 0 until init_done
  task automatic build(input int p, input int trp, input int trfc, input int tmrd);
    int t;
    int n;
    exp_cmd_q.delete();
    exp_tag_q.delete();
    repeat (atleast(p, 1)) begin exp_cmd_q.push_back(NOP); exp_tag_q.push_back("R2"); end
    exp_cmd_q.push_back(PRE); exp_tag_q.push_back("R2");
    repeat (atleast(trp, 2) - 1) begin exp_cmd_q.push_back(NOP); exp_tag_q.push_back("R3"); end
    t = atleast(trp, 2);
    n = 0;
    forever begin
      exp_cmd_q.push_back(REF);
      exp_tag_q.push_back((n == 0) ? "R3" : "R4");
      n++;
      repeat (atleast(trfc, 2) - 1) begin exp_cmd_q.push_back(NOP); exp_tag_q.push_back("R4"); end
      t += atleast(trfc, 2);
      if (n >= NREF && t >= MIN_PHASE) break;
    end
    exp_cmd_q.push_back(LMR); exp_tag_q.push_back("R5");
    repeat (atleast(tmrd, 2) - 1) begin exp_cmd_q.push_back(NOP); exp_tag_q.push_back("R8"); end
  endtask

  task automatic check_reset_state(input string tag);
    chk(tag, "cke", cke, 0);
    chk(tag, "cmd", {cs_n, ras_n, cas_n, we_n}, NOP);
    chk(tag, "init_done", done, 0);
    chk(tag, "rfsh_fast", fast, 1);
    chk(tag, "rfsh_units", units, 1);
  endtask

  task automatic check_cycle(input logic [3:0] ecmd, input string tag, input bit edone);
    longint eaddr;
    eaddr = (ecmd == PRE) ? 'h400 : (ecmd == LMR) ? MODE_VAL : 0;
    chk(tag, "cmd", {cs_n, ras_n, cas_n, we_n}, ecmd);
    chk((ecmd == LMR) ? "R6" : "R2", "addr", addr, eaddr);
    chk("R6", "ba", ba, 0);
    chk("R10", "cke", cke, 1);
    chk("R7", "mode_host_addr", host, (ecmd == LMR) ? HOST_STD : 0);
    chk("R7", "lp mode_host_addr", lp_host, (ecmd == LMR) ? HOST_LP : 0);
    chk(tag, "lp cmd", {lp_cs_n, lp_ras_n, lp_cas_n, lp_we_n}, ecmd);
    chk("R8", "init_done", done, edone);
    chk("R9", "rfsh_fast", fast, !edone);
    chk("R9", "rfsh_units", units, edone ? (cfg_rf >> 4) : 1);
  endtask

  task automatic run_case(input int p, input int trp, input int trfc,
                          input int tmrd, input int rf);
    @(negedge clk);
    rst_n     = 1'b0;
    cfg_pwrup = 16'(p);
    cfg_trp   = 8'(trp);
    cfg_trfc  = 8'(trfc);
    cfg_tmrd  = 8'(tmrd);
    cfg_rf    = 16'(rf);
    build(p, trp, trfc, tmrd);
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    // two synchronizer cycles: still in reset state (R1)
    repeat (2) begin
      @(negedge clk);
      check_reset_state("R1");
    end
    foreach (exp_cmd_q[i]) begin
      @(negedge clk);
      check_cycle(exp_cmd_q[i], exp_tag_q[i], 1'b0);
    end
    repeat (6) begin
      @(negedge clk);
      check_cycle(NOP, "R8", 1'b1);
    end
  endtask

  initial begin
    run_case(20, 3, 10, 2, 448);     // phase floor governs refresh count
    run_case(1, 1, 0, 0, 'h1000);    // every wait clamped
    run_case(5, 2, 70, 5, 'h0123);   // only the minimum two refreshes
    run_case(0, 7, 31, 9, 'hFFFF);   // zero power-up count, odd spacings
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired: got 0 expected 1");
    summary();
    $finish;
  end
endmodule